// File: doc/BRIEF.md
# Banked Memory Address Translator

This block sits between a CPU, a video fetch unit and a set of external memories. It widens both address spaces by looking up small bank registers. A CPU address in the upper 32 KB becomes a 19-bit physical program ROM address. A 13-bit video pattern address becomes an 18-bit physical pattern ROM address. Nametable fetches are folded onto a 2 KB internal video RAM, and CPU accesses to the 8 KB work RAM window are enabled or blocked.

The CPU programs the block with writes to four decoded register slots in the upper address space. An index slot holds two layout mode bits and a 3-bit pointer. A data slot loads the bank register that the pointer selects. Two more slots hold the mirroring choice and the work RAM control bits. All address outputs are combinational in the incoming addresses. Register writes are captured on the clock edge of the write cycle.

Top module: `bank_xlate_top`

## Requirements
- R1: A write with `cpu_addr[15:13]=100` and `cpu_addr[0]=0` sets the pattern layout bit from data bit 7 and the program layout bit from data bit 6. It also sets the bank pointer from data bits 2..0. Data bits 5..3 are ignored.
- R2: A write with `cpu_addr[15:13]=100` and `cpu_addr[0]=1` loads the pointed-to bank register. Pointer 0 and pointer 1 store the data with bit 0 forced to 0. Pointers 2 to 5 store all 8 bits.
- R3: For pointer 6 or pointer 7, that write stores data bits 5..0 into program bank 0 or program bank 1, respectively.
- R4: `prg_addr` is {bank, `cpu_addr[12:0]`}, where the window is `cpu_addr[14:13]`. Window 1 always uses program bank 1. Window 3 always uses bank 0x3F.
- R5: With program layout 0, window 0 uses program bank 0 and window 2 uses bank 0x3E. With program layout 1, the two windows are exchanged.
- R6: With pattern layout 0, `ppu_addr` 0x0000–0x0FFF maps through two 2 KB banks (register 0 below 0x0800, register 1 above). `chr_addr` is (bank<<10)|`ppu_addr[10:0]`. Addresses 0x1000–0x1FFF map through four 1 KB banks, registers 2..5 in ascending order, with `chr_addr` = (bank<<10)|`ppu_addr[9:0]`.
- R7: With pattern layout 1, the two halves of R6 are exchanged. The 1 KB banks cover 0x0000–0x0FFF and the 2 KB banks cover 0x1000–0x1FFF.
- R8: A write with `cpu_addr[15:13]=101` and `cpu_addr[0]=0` sets mirroring from data bit 0. `ntram_addr[10]` equals `ppu_addr[10]` when mirroring is 0 and `ppu_addr[11]` when it is 1. `ntram_addr[9:0]` equals `ppu_addr[9:0]`.
- R9: A write with `cpu_addr[15:13]=101` and `cpu_addr[0]=1` sets RAM enable from data bit 7 and write protect from data bit 6. A CPU read in the window `cpu_addr[15:13]=011` asserts `wram_rd_en` and returns `wram_rdata` only when enabled. Otherwise `cpu_rdata` is 0x00. `wram_addr` is `cpu_addr[12:0]`.
- R10: `wram_wr_en` is asserted only for a CPU write in the work RAM window while RAM is enabled and write protect is clear.
- R11: After reset, all bank registers, both layout bits, the pointer and mirroring are 0, RAM is enabled, and write protect is clear.
- R12: Writes to addresses with `cpu_addr[15:13]` equal to 110 or 111, or below 0x8000, change no mapping or RAM control state.
- R13: A register write takes effect on the outputs after the rising clock edge that ends the write cycle, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_rd | input | 1 | CPU read strobe for this cycle |
| wram_rdata | input | 8 | Read data from work RAM |
| ppu_addr | input | 13 | Video pattern/nametable address |
| prg_addr | output | 19 | Physical program ROM address |
| chr_addr | output | 18 | Physical pattern ROM address |
| ntram_addr | output | 11 | Internal video RAM address |
| wram_addr | output | 13 | Work RAM address |
| wram_rd_en | output | 1 | Work RAM read enable |
| wram_wr_en | output | 1 | Work RAM write enable |
| cpu_rdata | output | 8 | Gated work RAM read data to CPU |

## Verification
The bench loads each bank register with a distinct value whose low bit is set where masking matters. It then sweeps the whole 8 KB pattern space and a stride through the 32 KB program space under both layout settings, so any wrong register pick, swapped half or masking fault shows as a wrong upper field. A second bank set with different values tells register aliasing apart from a correct lookup. Nametable sweeps cover all four quadrants under both mirroring choices. RAM gating is tried in all three enable and protect combinations, plus reads outside the window. Writes into the ignored slots are followed by a re-sweep, so any state they touch becomes visible at the outputs.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int CPU_AW    = 16;
    localparam int PPU_AW    = 13;
    localparam int DW        = 8;
    localparam int PRG_BW    = 6;
    localparam int PRG_OFS_W = 13;
    localparam int PRG_AW    = PRG_BW + PRG_OFS_W;
    localparam int CHR_BW    = 8;
    localparam int CHR_OFS_W = 10;
    localparam int CHR_AW    = CHR_BW + CHR_OFS_W;
    localparam int N_CHR     = 6;
    localparam int N_PRG     = 2;
    localparam int NT_AW     = 11;
    localparam int WRAM_AW   = 13;

    typedef struct packed {
        logic                             chr_swap;
        logic                             prg_swap;
        logic [2:0]                       ptr;
        logic [N_CHR-1:0][CHR_BW-1:0]     chr_bank;
        logic [N_PRG-1:0][PRG_BW-1:0]     prg_bank;
        logic                             mirror_v;
        logic                             ram_on;
        logic                             ram_lock;
    } map_regs_t;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [3:0]    slot,      // {addr[15:13], addr[0]}
    input  logic [DW-1:0] wdata,
    output map_regs_t     regs_q
);
    map_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr && slot[3]) begin
            case (slot[2:0])
                3'b000: begin
                    regs_d.chr_swap = wdata[7];
                    regs_d.prg_swap = wdata[6];
                    regs_d.ptr      = wdata[2:0];
                end
                3'b001: begin
                    for (int i = 0; i < N_CHR; i++) begin
                        if (regs_q.ptr == 3'(i)) begin
                            if (i < 2) regs_d.chr_bank[i] = {wdata[CHR_BW-1:1], 1'b0};
                            else       regs_d.chr_bank[i] = wdata[CHR_BW-1:0];
                        end
                    end
                    for (int j = 0; j < N_PRG; j++) begin
                        if (regs_q.ptr == 3'(N_CHR + j))
                            regs_d.prg_bank[j] = wdata[PRG_BW-1:0];
                    end
                end
                3'b010: regs_d.mirror_v = wdata[0];
                3'b011: begin
                    regs_d.ram_on   = wdata[7];
                    regs_d.ram_lock = wdata[6];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q        <= '0;
            regs_q.ram_on <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/prg_map.sv
module prg_map
    import xlate_pkg::*;
(
    input  logic                          swap,
    input  logic [N_PRG-1:0][PRG_BW-1:0]  bank,
    input  logic [PRG_OFS_W+1:0]          addr,
    output logic [PRG_AW-1:0]             phys
);
    localparam logic [PRG_BW-1:0] LAST_BANK = '1;
    localparam logic [PRG_BW-1:0] NEXT_LAST = LAST_BANK - 1'b1;

    logic [PRG_BW-1:0] sel;

    always_comb begin
        case (addr[PRG_OFS_W+1:PRG_OFS_W])
            2'd0:    sel = swap ? NEXT_LAST : bank[0];
            2'd1:    sel = bank[1];
            2'd2:    sel = swap ? bank[0] : NEXT_LAST;
            default: sel = LAST_BANK;
        endcase
        phys = {sel, addr[PRG_OFS_W-1:0]};
    end
endmodule

// File: rtl/chr_map.sv
module chr_map
    import xlate_pkg::*;
(
    input  logic                          swap,
    input  logic [N_CHR-1:0][CHR_BW-1:0]  bank,
    input  logic [PPU_AW-1:0]             addr,
    output logic [CHR_AW-1:0]             phys
);
    logic              wide;
    logic [2:0]        idx;
    logic [CHR_BW-1:0] sel;

    always_comb begin
        wide = (addr[12] == swap);
        if (wide) idx = {2'b00, addr[11]};
        else      idx = 3'd2 + {1'b0, addr[11:10]};
        sel = bank[idx];
        if (wide)
            phys = {sel, {CHR_OFS_W{1'b0}}} | {{(CHR_AW-11){1'b0}}, addr[10:0]};
        else
            phys = {sel, addr[CHR_OFS_W-1:0]};
    end
endmodule

// File: rtl/ram_gate.sv
module ram_gate
    import xlate_pkg::*;
(
    input  logic              mirror_v,
    input  logic              ram_on,
    input  logic              ram_lock,
    input  logic [11:0]       nt_addr,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DW-1:0]     wram_rdata,
    output logic [NT_AW-1:0]  ntram_addr,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic              wram_rd_en,
    output logic              wram_wr_en,
    output logic [DW-1:0]     cpu_rdata
);
    logic hit;

    always_comb begin
        ntram_addr = {(mirror_v ? nt_addr[11] : nt_addr[10]), nt_addr[9:0]};
        hit        = (cpu_addr[CPU_AW-1:WRAM_AW] == 3'b011);
        wram_addr  = cpu_addr[WRAM_AW-1:0];
        wram_rd_en = cpu_rd && hit && ram_on;
        wram_wr_en = cpu_wr && hit && ram_on && !ram_lock;
        cpu_rdata  = wram_rd_en ? wram_rdata : '0;
    end
endmodule

// File: rtl/bank_xlate_top.sv
module bank_xlate_top
    import xlate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DW-1:0]      cpu_wdata,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [DW-1:0]      wram_rdata,
    input  logic [PPU_AW-1:0]  ppu_addr,
    output logic [PRG_AW-1:0]  prg_addr,
    output logic [CHR_AW-1:0]  chr_addr,
    output logic [NT_AW-1:0]   ntram_addr,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic               wram_rd_en,
    output logic               wram_wr_en,
    output logic [DW-1:0]      cpu_rdata
);
    map_regs_t regs_q;

    xlate_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_wr),
        .slot   ({cpu_addr[15:13], cpu_addr[0]}),
        .wdata  (cpu_wdata),
        .regs_q (regs_q)
    );

    prg_map u_prg (
        .swap (regs_q.prg_swap),
        .bank (regs_q.prg_bank),
        .addr (cpu_addr[PRG_OFS_W+1:0]),
        .phys (prg_addr)
    );

    chr_map u_chr (
        .swap (regs_q.chr_swap),
        .bank (regs_q.chr_bank),
        .addr (ppu_addr),
        .phys (chr_addr)
    );

    ram_gate u_ram (
        .mirror_v   (regs_q.mirror_v),
        .ram_on     (regs_q.ram_on),
        .ram_lock   (regs_q.ram_lock),
        .nt_addr    (ppu_addr[11:0]),
        .cpu_addr   (cpu_addr),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .wram_rdata (wram_rdata),
        .ntram_addr (ntram_addr),
        .wram_addr  (wram_addr),
        .wram_rd_en (wram_rd_en),
        .wram_wr_en (wram_wr_en),
        .cpu_rdata  (cpu_rdata)
    );
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic [12:0] ppu_addr,
    input logic [18:0] prg_addr,
    input logic [17:0] chr_addr,
    input logic [10:0] ntram_addr,
    input logic        wram_wr_en,
    input logic        wram_rd_en,
    input logic [7:0]  cpu_rdata
);
    AST_TOP_WINDOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_addr[18:13] == 6'h3F)); // R4

    AST_PRG_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[12:0] == cpu_addr[12:0]); // R4

    AST_CHR_PAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[9:0] == ppu_addr[9:0]); // R6

    AST_NT_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ntram_addr[9:0] == ppu_addr[9:0]); // R8

    AST_RDATA_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        !wram_rd_en |-> (cpu_rdata == 8'h00)); // R9

    AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_wr && cpu_addr[15:13] == 3'b101 && cpu_addr[0] && cpu_wdata[6])
        |-> !wram_wr_en); // R10
endmodule

bind bank_xlate_top xlate_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_wr     (cpu_wr),
    .ppu_addr   (ppu_addr),
    .prg_addr   (prg_addr),
    .chr_addr   (chr_addr),
    .ntram_addr (ntram_addr),
    .wram_wr_en (wram_wr_en),
    .wram_rd_en (wram_rd_en),
    .cpu_rdata  (cpu_rdata)
);

// File: tb/tb_bank_xlate_top.sv
`timescale 1ns/1ps
module tb_bank_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  wram_rdata = 8'h5A;
    logic [12:0] ppu_addr = '0;
    logic [18:0] prg_addr;
    logic [17:0] chr_addr;
    logic [10:0] ntram_addr;
    logic [12:0] wram_addr;
    logic        wram_rd_en, wram_wr_en;
    logic [7:0]  cpu_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // bench-side register image, built from what the bench writes
    int m_chr[6];
    int m_prg[2];
    int m_pmode, m_cmode, m_mir;

    always #4 clk = ~clk;

    bank_xlate_top dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
    endtask

    function automatic int exp_prg(input int a);
        int w, b;
        w = (a >> 13) & 3;
        case (w)
            0: b = m_pmode ? 'h3E : m_prg[0];
            1: b = m_prg[1];
            2: b = m_pmode ? m_prg[0] : 'h3E;
            default: b = 'h3F;
        endcase
        return (b << 13) | (a & 'h1FFF);
    endfunction

    function automatic int exp_chr(input int a);
        int half;
        half = (a >> 12) & 1;
        if (half == m_cmode) return (m_chr[(a >> 11) & 1] << 10) | (a & 'h7FF);
        return (m_chr[2 + ((a >> 10) & 3)] << 10) | (a & 'h3FF);
    endfunction

    task automatic load_banks(input int v0, input int v1, input int v2, input int v3,
                              input int v4, input int v5, input int p0, input int p1);
        int vals[8];
        vals = '{v0, v1, v2, v3, v4, v5, p0, p1};
        for (int i = 0; i < 8; i++) begin
            wr_reg('h8000, i);
            wr_reg('h8001, vals[i]);
        end
        for (int i = 0; i < 6; i++) m_chr[i] = (i < 2) ? (vals[i] & 'hFE) : vals[i];
        m_prg[0] = vals[6] & 'h3F;
        m_prg[1] = vals[7] & 'h3F;
        m_pmode = 0; m_cmode = 0;
    endtask

    task automatic sweep_prg(input string req, input int step);
        for (int a = 'h8000; a <= 'hFFFF; a += step) begin
            cpu_addr = 16'(a); #1;
            chk(req, int'(prg_addr), exp_prg(a));
        end
    endtask

    task automatic sweep_chr(input string req, input int step);
        for (int a = 0; a < 'h2000; a += step) begin
            ppu_addr = 13'(a); #1;
            chk(req, int'(chr_addr), exp_chr(a));
        end
    endtask

    initial begin
        #1600000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;

        // R11: reset state
        for (int i = 0; i < 6; i++) m_chr[i] = 0;
        m_prg = '{0, 0}; m_pmode = 0; m_cmode = 0; m_mir = 0;
        sweep_prg("R11", 'h0FFF);
        sweep_chr("R11", 'h01FF);
        ppu_addr = 13'h0C05; #1; chk("R11", int'(ntram_addr), 'h405);
        cpu_addr = 16'h6123; cpu_rd = 1'b1; #1;
        chk("R11", int'(cpu_rdata), 'h5A);
        chk("R11", int'(wram_rd_en), 1);
        cpu_rd = 1'b0;

        // R2 R3: bank loading with masking
        load_banks('h13, 'h57, 'hA1, 'hB2, 'hC3, 'hFF, 'hC5, 'h7A);
        // R4: mode 0 program map
        sweep_prg("R4", 'h0101);
        sweep_chr("R6", 1);
        // R5: program layout 1
        wr_reg('h8000, 'h40); m_pmode = 1;
        sweep_prg("R5", 'h0101);
        // R7: pattern layout 1 with program layout 0
        wr_reg('h8000, 'h80); m_pmode = 0; m_cmode = 1;
        sweep_chr("R7", 1);
        sweep_prg("R5", 'h0407);

        // second value set, R2 R3 again
        load_banks('h01, 'hFE, 'h00, 'h7F, 'h80, 'h3C, 'hFF, 'h40);
        sweep_chr("R2", 3);
        sweep_prg("R3", 'h0203);
        wr_reg('h8000, 'hC0); m_pmode = 1; m_cmode = 1;
        sweep_chr("R7", 5);
        sweep_prg("R5", 'h0203);

        // R1: noise bits 5..3 ignored, pointer from bits 2..0
        wr_reg('h8000, 'h3D); m_pmode = 0; m_cmode = 0;
        wr_reg('h8001, 'h99); m_chr[5] = 'h99;
        ppu_addr = 13'h1C07; #1; chk("R1", int'(chr_addr), ('h99 << 10) | 'h07);
        sweep_prg("R1", 'h0FFF);

        // R13: write not visible before the capturing edge
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_wdata = 8'h40; cpu_wr = 1'b1; #1;
        chk("R13", int'(prg_addr), exp_prg('h8000));
        @(posedge clk); #1;
        m_pmode = 1;
        chk("R13", int'(prg_addr), exp_prg('h8000));
        @(negedge clk); cpu_wr = 1'b0; #1;

        // R8: mirroring
        for (int mv = 1; mv >= 0; mv--) begin
            wr_reg('hA000, 'hFE | mv); m_mir = mv;
            for (int a = 0; a < 'h1000; a += 'h11) begin
                ppu_addr = 13'(a); #1;
                chk("R8", int'(ntram_addr),
                    ((mv ? ((a >> 11) & 1) : ((a >> 10) & 1)) << 10) | (a & 'h3FF));
            end
        end

        // R12: ignored slots and low addresses
        wr_reg('hC000, 'hFF); wr_reg('hC001, 'hFF);
        wr_reg('hE000, 'hC1); wr_reg('hE001, 'h47);
        wr_reg('h4000, 'hFF); wr_reg('h6001, 'h41); wr_reg('h0000, 'hC7);
        sweep_prg("R12", 'h0101);
        sweep_chr("R12", 7);
        ppu_addr = 13'h0800; #1; chk("R12", int'(ntram_addr), 'h000);
        cpu_addr = 16'h7000; cpu_rd = 1'b1; #1;
        chk("R12", int'(cpu_rdata), 'h5A);
        cpu_rd = 1'b0;

        // R9 R10: RAM gating
        wr_reg('hA001, 'h00);
        cpu_addr = 16'h7ABC; cpu_rd = 1'b1; wram_rdata = 8'hC3; #1;
        chk("R9", int'(cpu_rdata), 0);
        chk("R9", int'(wram_rd_en), 0);
        chk("R9", int'(wram_addr), 'h1ABC);
        cpu_rd = 1'b0;
        @(negedge clk); cpu_addr = 16'h6000; cpu_wr = 1'b1; #1;
        chk("R10", int'(wram_wr_en), 0);
        @(negedge clk); cpu_wr = 1'b0;
        wr_reg('hA001, 'hC0);
        cpu_addr = 16'h6F00; cpu_rd = 1'b1; #1;
        chk("R9", int'(cpu_rdata), 'hC3);
        chk("R9", int'(wram_rd_en), 1);
        cpu_addr = 16'h8F00; #1;
        chk("R9", int'(wram_rd_en), 0);
        chk("R9", int'(cpu_rdata), 0);
        cpu_rd = 1'b0;
        @(negedge clk); cpu_addr = 16'h6010; cpu_wr = 1'b1; #1;
        chk("R10", int'(wram_wr_en), 0);
        @(negedge clk); cpu_wr = 1'b0;
        wr_reg('hA001, 'h80);
        @(negedge clk); cpu_addr = 16'h7FFF; cpu_wr = 1'b1; #1;
        chk("R10", int'(wram_wr_en), 1);
        @(negedge clk); cpu_addr = 16'h5FFF; #1;
        chk("R10", int'(wram_wr_en), 0);
        @(negedge clk); cpu_wr = 1'b0;

        // R11: reset again restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1; #1;
        for (int i = 0; i < 6; i++) m_chr[i] = 0;
        m_prg = '{0, 0}; m_pmode = 0; m_cmode = 0;
        sweep_prg("R11", 'h0FFF);
        sweep_chr("R11", 'h00FF);
        cpu_addr = 16'h6000; cpu_rd = 1'b1; #1;
        chk("R11", int'(wram_rd_en), 1);
        cpu_rd = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule